// File: doc/BRIEF.md
# Clock policy engine controller

This block sits between a simple synchronous register port and the clock gates of a clock unit. It selects one of four power/performance policies, and it drives a vector of clock enables taken from the mask register of whichever policy is active. Each bit of a mask turns one downstream clock on for that policy. A clock keeps the same bit position in all four masks.

Every register other than the access register is protected. A write to one of them lands only after software has opened access with a key word. Software changes policy by writing a target policy and then setting the GO bit. The GO bit stays set while the engine settles, and it clears itself when the operation ends. The settle time is a fixed count of clock cycles and stands in for a voltage ramp.

There are two request modes. In the synchronous mode, the target becomes active at once and GO clears after the settle time. In the asynchronous mode, the active policy is kept for the whole settle time, and the target is copied to it when the settle time ends. A stop write aborts any operation that is in flight.

Top module: `clk_policy_ctrl`

## Requirements
- R1: After reset the active policy is 2, all four masks are all ones, access is closed, the target is 2, GO reads 0 and `clk_en` is all ones.
- R2: At word address 0, a write of 0xA5A501 opens access and a write of 0xA5A500 closes it. A write to address 0 whose bits 31:1 differ from the key has no effect. Read bit 0 of address 0 shows whether access is open.
- R3: While access is closed, writes to addresses 1 to 7 have no effect. Reads are never blocked.
- R4: The masks for policies 0, 1, 2 and 3 sit at word addresses 4, 5, 6 and 7. Each can be read back, and `clk_en` equals the mask of the active policy.
- R5: Address 1 is the control register, with GO at bit 0. A write with GO set while idle makes bit 0 read 1 from the next cycle for exactly SETTLE cycles, after which it reads 0. A GO write while busy is ignored and does not lengthen the operation.
- R6: A GO write with bit 1 (synchronous) set makes the target policy (address 2, bits 1:0) active in the next cycle, and the engine then stays busy for SETTLE cycles. Bit 1 takes priority over bit 2.
- R7: A GO write with bit 2 (auto-copy) set and bit 1 clear keeps the active policy unchanged while busy. The target is copied to the active policy on the same edge that clears GO. The active policy reads at address 1, bits 9:8.
- R8: While the engine settles, masks stay writable. A new value written to the target's mask shows on `clk_en` only once the copy happens, and this includes a mask write that lands on the completion edge itself.
- R9: Writing 1 to bit 0 of address 3 aborts any operation: busy clears and no copy is made, even when the stop lands on the completion edge. Bit 0 of address 3 then reads 1 for exactly one cycle. A later GO works normally.
- R10: A GO write with neither bit 1 nor bit 2 set only runs the settle delay and leaves the active policy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_en | output | CLK_W | Clock enables of the active policy |

## Verification
Two things can land on the same clock edge: the end of an asynchronous settle, and a register write. The bench times a stop write, and in a separate run a write to the target's mask, so that it is captured on exactly the edge where the settle counter expires. For the stop, the expected result is no copy: the active policy is unchanged, GO reads 0 and the stop bit pulses once. For the mask write, the expected result is that the copy happens and `clk_en` shows the newly written mask in the very next cycle.

// File: rtl/clk_pol_pkg.sv
// Shared constants for the clock policy controller: register word
// addresses, control bit positions, access key and policy count.
package clk_pol_pkg;
    localparam int NPOL      = 4;
    localparam int PIDX_W    = 2;
    localparam int RESET_POL = 2;
    localparam logic [31:0] ACC_KEY = 32'h00A5_A500;

    localparam int A_ACCESS = 0;
    localparam int A_CTRL   = 1;
    localparam int A_TARGET = 2;
    localparam int A_STOP   = 3;
    localparam int A_MASK0  = 4;

    localparam int B_GO   = 0;
    localparam int B_SYNC = 1;
    localparam int B_AC   = 2;
endpackage

// File: rtl/clk_pol_access.sv
// Write-access guard. Holds the open/closed flag, which changes only
// on a write to address 0 carrying the key. Assumes one write per cycle.
module clk_pol_access #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              acc_open,
    output logic              prot_we
);
    import clk_pol_pkg::*;

    logic at_acc;
    logic key_ok;

    // Decode the access address and compare the key field.
    always_comb begin
        at_acc = (bus_addr == ADDR_W'(A_ACCESS));
        key_ok = (bus_wdata[31:1] == ACC_KEY[31:1]);
    end

    // Open or close access on a keyed write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_open <= 1'b0;
        else if (bus_wr && at_acc && key_ok)
            acc_open <= bus_wdata[0];
    end

    // A protected write is any accepted write away from address 0.
    assign prot_we = bus_wr && acc_open && !at_acc;
endmodule

// File: rtl/clk_pol_masks.sv
// The four policy mask registers, one per policy at consecutive word
// addresses. Writes arrive already qualified by the access guard.
module clk_pol_masks #(
    parameter int ADDR_W = 3,
    parameter int CLK_W  = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 prot_we,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [clk_pol_pkg::NPOL-1:0][CLK_W-1:0] mask_q
);
    import clk_pol_pkg::*;

    for (genvar p = 0; p < NPOL; p++) begin : g_mask
        // Hold the mask for policy p; reset enables every clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[p] <= '1;
            else if (prot_we && bus_addr == ADDR_W'(A_MASK0 + p))
                mask_q[p] <= bus_wdata[CLK_W-1:0];
        end
    end
endmodule

// File: rtl/clk_pol_engine.sv
// Policy engine. It holds the target and active policy and runs the
// GO/settle handshake in synchronous or auto-copy mode. A stop aborts
// the operation and wins over completion on the same edge.
// Assumes SETTLE >= 1.
module clk_pol_engine #(
    parameter int SETTLE = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           go_wr,
    input  logic                           go_sync,
    input  logic                           go_ac,
    input  logic                           stop_wr,
    input  logic                           tgt_wr,
    input  logic [clk_pol_pkg::PIDX_W-1:0] tgt_d,
    output logic [clk_pol_pkg::PIDX_W-1:0] target,
    output logic [clk_pol_pkg::PIDX_W-1:0] active,
    output logic                           busy,
    output logic                           stop_pend
);
    import clk_pol_pkg::*;

    localparam int CNT_W = $clog2(SETTLE + 1);

    logic [CNT_W-1:0] cnt;
    logic             copy_mode;

    // Target policy register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target <= PIDX_W'(RESET_POL);
        else if (tgt_wr)
            target <= tgt_d;
    end

    // Stop indication stays high for the one cycle after a stop write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_pend <= 1'b0;
        else
            stop_pend <= stop_wr;
    end

    // Handshake: start on GO, count the settle time, copy in auto-copy mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            copy_mode <= 1'b0;
            active    <= PIDX_W'(RESET_POL);
        end else if (stop_wr) begin
            busy      <= 1'b0;
            cnt       <= '0;
            copy_mode <= 1'b0;
        end else if (busy) begin
            if (cnt == CNT_W'(1)) begin
                busy <= 1'b0;
                if (copy_mode)
                    active <= target;
            end
            cnt <= cnt - CNT_W'(1);
        end else if (go_wr) begin
            busy      <= 1'b1;
            cnt       <= CNT_W'(SETTLE);
            copy_mode <= go_ac && !go_sync;
            if (go_sync)
                active <= target;
        end
    end
endmodule

// File: rtl/clk_policy_ctrl.sv
// Top of the clock policy controller. It connects the access guard, the
// mask registers and the engine, decodes the protected writes, muxes the
// read data and drives the enables of the active policy.
module clk_policy_ctrl #(
    parameter int ADDR_W = 3,
    parameter int CLK_W  = 32,
    parameter int SETTLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CLK_W-1:0]  clk_en
);
    import clk_pol_pkg::*;

    logic                             acc_open;
    logic                             prot_we;
    logic [NPOL-1:0][CLK_W-1:0]       mask_q;
    logic [PIDX_W-1:0]                target;
    logic [PIDX_W-1:0]                act_pol;
    logic                             eng_busy;
    logic                             stop_pend;
    logic                             go_wr;
    logic                             stop_wr;
    logic                             tgt_wr;

    clk_pol_access #(.ADDR_W(ADDR_W)) u_access (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .acc_open(acc_open), .prot_we(prot_we)
    );

    clk_pol_masks #(.ADDR_W(ADDR_W), .CLK_W(CLK_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mask_q(mask_q)
    );

    // Decode the protected writes that reach the engine.
    always_comb begin
        go_wr   = prot_we && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[B_GO];
        stop_wr = prot_we && bus_addr == ADDR_W'(A_STOP) && bus_wdata[0];
        tgt_wr  = prot_we && bus_addr == ADDR_W'(A_TARGET);
    end

    clk_pol_engine #(.SETTLE(SETTLE)) u_engine (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr),
        .go_sync(bus_wdata[B_SYNC]), .go_ac(bus_wdata[B_AC]),
        .stop_wr(stop_wr), .tgt_wr(tgt_wr), .tgt_d(bus_wdata[PIDX_W-1:0]),
        .target(target), .active(act_pol), .busy(eng_busy),
        .stop_pend(stop_pend)
    );

    // Read data multiplexer; reads are never blocked.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_ACCESS))
            bus_rdata[0] = acc_open;
        else if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[0]   = eng_busy;
            bus_rdata[9:8] = act_pol;
        end else if (bus_addr == ADDR_W'(A_TARGET))
            bus_rdata[PIDX_W-1:0] = target;
        else if (bus_addr == ADDR_W'(A_STOP))
            bus_rdata[0] = stop_pend;
        else begin
            for (int p = 0; p < NPOL; p++)
                if (bus_addr == ADDR_W'(A_MASK0 + p))
                    bus_rdata[CLK_W-1:0] = mask_q[p];
        end
    end

    // The enables follow the mask of the active policy.
    assign clk_en = mask_q[act_pol];
endmodule

// File: rtl/clk_pol_checker.sv
// Property checker for clk_policy_ctrl, attached with bind. It watches
// the bus, the access flag, the engine state and the mask registers.
module clk_pol_checker #(
    parameter int ADDR_W = 3,
    parameter int CLK_W  = 32
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    bus_wr,
    input logic [ADDR_W-1:0]                       bus_addr,
    input logic [31:0]                             bus_wdata,
    input logic                                    acc_open,
    input logic                                    eng_busy,
    input logic [1:0]                              act_pol,
    input logic                                    stop_pend,
    input logic [clk_pol_pkg::NPOL-1:0][CLK_W-1:0] mask_q
);
    import clk_pol_pkg::*;

    logic stop_now;
    assign stop_now = bus_wr && acc_open && bus_addr == ADDR_W'(A_STOP) && bus_wdata[0];

    p_bad_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_ACCESS) && bus_wdata[31:1] != ACC_KEY[31:1])
        |=> $stable(acc_open));

    p_closed_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !acc_open) |=> $stable(mask_q));

    p_go_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc_open && bus_addr == ADDR_W'(A_CTRL) && bus_wdata[B_GO] && !eng_busy)
        |=> eng_busy);

    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(act_pol));

    p_stop_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> (!eng_busy && stop_pend && $stable(act_pol)));

    p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend && !stop_now) |=> !stop_pend);
endmodule

bind clk_policy_ctrl clk_pol_checker #(.ADDR_W(ADDR_W), .CLK_W(CLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .acc_open(acc_open), .eng_busy(eng_busy),
    .act_pol(act_pol), .stop_pend(stop_pend), .mask_q(mask_q)
);

// File: tb/clk_policy_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for clk_policy_ctrl: one task per scenario.
module clk_policy_ctrl_bench;
    localparam int ADDR_W = 3;
    localparam int CLK_W  = 32;
    localparam int S      = 8;
    localparam logic [31:0] KEY = 32'h00A5_A500;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [CLK_W-1:0]  clk_en;
    int checks = 0;
    int errors = 0;

    clk_policy_ctrl #(.ADDR_W(ADDR_W), .CLK_W(CLK_W), .SETTLE(S)) u_clk_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write is captured on the next posedge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(1, d); check("R1 active/go", d, 32'h200);
        rd(0, d); check("R1 access", d, 0);
        rd(2, d); check("R1 target", d, 2);
        for (int p = 4; p < 8; p++) begin rd(p, d); check("R1 mask", d, 32'hFFFF_FFFF); end
        check("R1 clk_en", clk_en, 32'hFFFF_FFFF);
    endtask

    task automatic t_access;
        logic [31:0] d;
        wr(0, 32'h1234_5601); rd(0, d); check("R2 wrong key", d, 0);
        wr(0, KEY | 1);       rd(0, d); check("R2 open", d, 1);
        wr(0, 32'h00A5_A401); rd(0, d); check("R2 wrong key while open", d, 1);
        wr(0, KEY);           rd(0, d); check("R2 close", d, 0);
    endtask

    task automatic t_closed;
        logic [31:0] d;
        wr(4, 32'h0);  rd(4, d); check("R3 mask closed", d, 32'hFFFF_FFFF);
        wr(2, 32'h1);  rd(2, d); check("R3 target closed", d, 2);
        wr(1, 32'h3);  rd(1, d); check("R3 go closed", d, 32'h200);
        wr(0, KEY | 1);
    endtask

    task automatic t_masks;
        logic [31:0] d;
        wr(4, 32'h1); wr(5, 32'h2); wr(6, 32'hA5); wr(7, 32'h8);
        rd(4, d); check("R4 mask0", d, 1);
        rd(5, d); check("R4 mask1", d, 2);
        rd(6, d); check("R4 mask2", d, 32'hA5);
        rd(7, d); check("R4 mask3", d, 8);
        check("R4 clk_en policy2", clk_en, 32'hA5);
    endtask

    task automatic t_plain_go;
        logic [31:0] d;
        wr(2, 0);
        wr(1, 32'h1);
        rd(1, d); check("R5 busy", d, 32'h201);
        wr(1, 32'h1);
        repeat (S-2) @(negedge clk);
        rd(1, d); check("R5 still busy", d, 32'h201);
        @(negedge clk);
        rd(1, d); check("R5 go clears, R10 active kept", d, 32'h200);
        check("R10 clk_en", clk_en, 32'hA5);
    endtask

    task automatic t_sync;
        logic [31:0] d;
        wr(2, 1);
        wr(1, 32'h7);
        rd(1, d); check("R6 sync switch", d, 32'h101);
        check("R6 clk_en", clk_en, 2);
        repeat (S-1) @(negedge clk);
        rd(1, d); check("R6 busy to end", d, 32'h101);
        @(negedge clk);
        rd(1, d); check("R6 done", d, 32'h100);
    endtask

    task automatic t_async;
        logic [31:0] d;
        wr(2, 3);
        wr(1, 32'h5);
        rd(1, d); check("R7 hold at start", d, 32'h101);
        repeat (S-1) @(negedge clk);
        rd(1, d); check("R7 hold before end", d, 32'h101);
        check("R7 clk_en before", clk_en, 2);
        @(negedge clk);
        rd(1, d); check("R7 copied", d, 32'h300);
        check("R7 clk_en after", clk_en, 8);
    endtask

    task automatic t_settle_write;
        logic [31:0] d;
        wr(2, 0);
        wr(1, 32'h5);
        wr(4, 32'h10);
        check("R8 no early effect", clk_en, 8);
        repeat (S-2) @(negedge clk);
        wr(4, 32'h20);
        rd(1, d); check("R8 copy done", d, 32'h000);
        check("R8 collision mask", clk_en, 32'h20);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        wr(2, 2);
        wr(1, 32'h5);
        repeat (S-1) @(negedge clk);
        wr(3, 1);
        rd(1, d); check("R9 abort no copy", d, 32'h000);
        rd(3, d); check("R9 stop reads 1", d, 1);
        @(negedge clk);
        rd(3, d); check("R9 stop self-clears", d, 0);
        wr(1, 32'h5);
        repeat (S) @(negedge clk);
        rd(1, d); check("R9 restart", d, 32'h200);
        check("R9 clk_en restart", clk_en, 32'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_access;
        t_closed;
        t_masks;
        t_plain_go;
        t_sync;
        t_async;
        t_settle_write;
        t_stop;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule